// File: doc/BRIEF.md
# Load-Store Data Memory Port

This block sits between an issue stage and a 32-bit data memory. It takes one load or store at a time. Each operation arrives with a base operand, an offset operand, store data, a transaction tag and an operation code. The code gives the access size (8, 16 or 32 bits), the direction, and whether a load is signed. The block adds the operands to form the byte address. It then raises a split-phase request on the memory port, with byte enables for the addressed lanes and store data moved onto those lanes. The request stays up until the memory grants it, and the block then waits for the read-valid strobe.

For loads, the block picks the addressed bytes out of the returned word and sign-extends or zero-extends them. It then presents the result with the original tag for out-of-order writeback. A store completes on the same read-valid strobe and returns its tag with zero data. An access that is not aligned to its own size never reaches memory. Its result comes back in the next cycle with the exception flag set.

Top module: `ldst_port`

## Requirements
- R1: `inReady` is high only while no operation is in flight. An operation is taken on a clock edge where `inValid` and `inReady` are both high. `inReady` then stays low until the cycle after that operation's result has been presented.
- R2: Once `memReq` rises, it stays high until an edge where `memGnt` is high, and it is low in the cycle after that grant. While `memReq` is high and not yet granted, `memAddr`, `memBe`, `memWe` and `memWdata` do not change.
- R3: The operation code `inOp` is laid out as follows. Bit 3 set means store. Bit 2 set means an unsigned load. Bits 1:0 give the size: 0 is byte, 1 is half-word, and 2 or 3 is word. `memWe` is high during a store request and low during a load request.
- R4: `memAddr` equals `inOpA + inOpB`, taken modulo 2^ADDR_W, with its two low bits forced to zero.
- R5: `memBe` has one bit per byte lane, where bit k is data bits 8k+7..8k. It is 4'b0001 shifted left by the low address bits for a byte access, 4'b0011 shifted left by them for a half-word access, and 4'b1111 for a word access.
- R6: For a store, `memWdata` equals the store data shifted left by 8 times the low two address bits.
- R7: A load result is the read word shifted right by 8 times the low address bits, then cut to the access size. A signed byte or half-word is sign-extended from its top bit. An unsigned one is zero-extended. A word is returned unchanged.
- R8: `resValid` is high for exactly one cycle, and this is the cycle after the edge on which `memRvalid` was seen. In that cycle `resTag` equals the tag taken with the operation and `resExc` is low. `resData` is zero for a store.
- R9: A half-word access with address bit 0 set, or a word access with either low address bit set, raises no `memReq`. In the cycle after it is taken, `resValid` is high with `resExc` high, `resData` zero and the operation's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Issue stage offers an operation |
| inReady | output | 1 | Unit idle, can take an operation |
| inOp | input | 4 | Operation code (store, unsigned, size) |
| inOpA | input | ADDR_W | Base address operand |
| inOpB | input | ADDR_W | Offset operand |
| inWdata | input | 32 | Store data, right-aligned |
| inTag | input | TAG_W | Transaction tag |
| memReq | output | 1 | Memory request |
| memGnt | input | 1 | Memory accepted the request |
| memAddr | output | ADDR_W | Word-aligned address |
| memWe | output | 1 | High for store, low for load |
| memBe | output | 4 | Byte lane enables |
| memWdata | output | 32 | Lane-steered store data |
| memRdata | input | 32 | Read word |
| memRvalid | input | 1 | Response strobe, one per request |
| resValid | output | 1 | Result present for one cycle |
| resTag | output | TAG_W | Tag of the finished operation |
| resData | output | 32 | Extended load data, zero for stores |
| resExc | output | 1 | Misaligned-access exception |

## Verification
The assertions assume that the memory follows the split-phase handshake. Grant arrives only while a request is up. Exactly one read-valid pulse follows each grant, and it comes at least one cycle after the grant, never in the same cycle. The bench memory model keeps to this. It holds grant low for a chosen number of wait cycles while the request is raised, pulses grant for one cycle, and pulses read-valid with the chosen word in the cycle after. The issue side lowers `inValid` right after each accepted operation. The issue side offers a new operation only after the previous result has been seen.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef struct packed {
    logic       store;
    logic       unsgn;
    logic [1:0] size;
  } memOp_t;

  typedef struct packed {
    logic take;
    logic grab;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } state_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    misalign,
  input  logic    memGnt,
  input  logic    memRvalid,
  output logic    inReady,
  output logic    memReq,
  output logic    resValid,
  output strobe_t strb
);

  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (inValid) begin
          strb.take = 1'b1;
          stateNext = misalign ? ST_RESP : ST_REQ;
        end
      end
      ST_REQ: begin
        if (memGnt) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRvalid) begin
          strb.grab = 1'b1;
          stateNext = ST_RESP;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign inReady  = (state == ST_IDLE);
  assign memReq   = (state == ST_REQ);
  assign resValid = (state == ST_RESP);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq);

  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memGnt |=> !memReq);

  // R1
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !inReady);

  // R8
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid && inReady);

endmodule

// File: rtl/ldst_dpath.sv
module ldst_dpath
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [3:0]        inOp,
  input  logic [ADDR_W-1:0] inOpA,
  input  logic [ADDR_W-1:0] inOpB,
  input  logic [DATA_W-1:0] inWdata,
  input  logic [TAG_W-1:0]  inTag,
  input  logic [DATA_W-1:0] memRdata,
  output logic              misalign,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W/8-1:0] memBe,
  output logic [DATA_W-1:0] memWdata,
  output logic [TAG_W-1:0]  resTag,
  output logic [DATA_W-1:0] resData,
  output logic              resExc
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  memOp_t              opIn;
  logic [1:0]          sizeIn;
  logic [ADDR_W-1:0]   effAddr;
  logic [OFF_W-1:0]    offIn;
  logic [OFF_W-1:0]    alignMask;
  logic [LANES-1:0]    beBase;
  logic [LANES-1:0]    beIn;
  logic [DATA_W-1:0]   wdataIn;

  memOp_t              opReg;
  logic [OFF_W-1:0]    offReg;
  logic [ADDR_W-1:0]   addrReg;
  logic [LANES-1:0]    beReg;
  logic [DATA_W-1:0]   wdReg;
  logic [TAG_W-1:0]    tagReg;
  logic                excReg;
  logic [DATA_W-1:0]   resultReg;

  logic [DATA_W-1:0]   rdShift;
  logic [DATA_W-1:0]   loadExt;
  logic                signByte;
  logic                signHalf;

  // Request-side decode from the issue inputs
  always_comb begin
    opIn    = memOp_t'(inOp);
    sizeIn  = (opIn.size == 2'd3) ? SZ_WORD : opIn.size;
    effAddr = inOpA + inOpB;
    offIn   = effAddr[OFF_W-1:0];
    case (sizeIn)
      SZ_BYTE: begin
        alignMask = '0;
        beBase    = LANES'(1);
      end
      SZ_HALF: begin
        alignMask = OFF_W'(1);
        beBase    = LANES'(3);
      end
      default: begin
        alignMask = '1;
        beBase    = '1;
      end
    endcase
    misalign = |(offIn & alignMask);
    beIn     = beBase << offIn;
    wdataIn  = inWdata << {offIn, 3'b000};
  end

  // Response-side lane selection and extension
  always_comb begin
    rdShift  = memRdata >> {offReg, 3'b000};
    signByte = rdShift[7]  & ~opReg.unsgn;
    signHalf = rdShift[15] & ~opReg.unsgn;
    case (opReg.size)
      SZ_BYTE: loadExt = {{(DATA_W-8){signByte}}, rdShift[7:0]};
      SZ_HALF: loadExt = {{(DATA_W-16){signHalf}}, rdShift[15:0]};
      default: loadExt = memRdata;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg     <= '0;
      offReg    <= '0;
      addrReg   <= '0;
      beReg     <= '0;
      wdReg     <= '0;
      tagReg    <= '0;
      excReg    <= 1'b0;
      resultReg <= '0;
    end else begin
      if (strb.take) begin
        opReg       <= opIn;
        opReg.size  <= sizeIn;
        offReg      <= offIn;
        addrReg     <= {effAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        beReg       <= beIn;
        wdReg       <= wdataIn;
        tagReg      <= inTag;
        excReg      <= misalign;
        resultReg   <= '0;
      end
      if (strb.grab) begin
        resultReg <= opReg.store ? '0 : loadExt;
      end
    end
  end

  assign memAddr  = addrReg;
  assign memWe    = opReg.store;
  assign memBe    = beReg;
  assign memWdata = wdReg;
  assign resTag   = tagReg;
  assign resData  = resultReg;
  assign resExc   = excReg;

  // R9
  grab_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.grab |-> !excReg);

  // R5
  be_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.take && !misalign |=> memBe != '0);

endmodule

// File: rtl/ldst_port.sv
module ldst_port
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [3:0]        inOp,
  input  logic [ADDR_W-1:0] inOpA,
  input  logic [ADDR_W-1:0] inOpB,
  input  logic [31:0]       inWdata,
  input  logic [TAG_W-1:0]  inTag,
  output logic              memReq,
  input  logic              memGnt,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memRvalid,
  output logic              resValid,
  output logic [TAG_W-1:0]  resTag,
  output logic [31:0]       resData,
  output logic              resExc
);

  strobe_t strb;
  logic    misalign;

  ldst_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .misalign  (misalign),
    .memGnt    (memGnt),
    .memRvalid (memRvalid),
    .inReady   (inReady),
    .memReq    (memReq),
    .resValid  (resValid),
    .strb      (strb)
  );

  ldst_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (32),
    .TAG_W  (TAG_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inOp     (inOp),
    .inOpA    (inOpA),
    .inOpB    (inOpB),
    .inWdata  (inWdata),
    .inTag    (inTag),
    .memRdata (memRdata),
    .misalign (misalign),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memBe    (memBe),
    .memWdata (memWdata),
    .resTag   (resTag),
    .resData  (resData),
    .resExc   (resExc)
  );

  // R2
  fields_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> $stable(memAddr) && $stable(memBe)
                          && $stable(memWe) && $stable(memWdata));

  // R9
  mis_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && misalign |=> !memReq && resValid && resExc);

endmodule

// File: tb/ldst_port_tb.sv
`timescale 1ns/1ps
module ldst_port_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [3:0]  inOp = '0;
  logic [31:0] inOpA = '0;
  logic [31:0] inOpB = '0;
  logic [31:0] inWdata = '0;
  logic [3:0]  inTag = '0;
  logic        memReq;
  logic        memGnt = 1'b0;
  logic [31:0] memAddr;
  logic        memWe;
  logic [3:0]  memBe;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memRvalid = 1'b0;
  logic        resValid;
  logic [3:0]  resTag;
  logic [31:0] resData;
  logic        resExc;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ldst_port u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inOp(inOp), .inOpA(inOpA), .inOpB(inOpB), .inWdata(inWdata),
    .inTag(inTag), .memReq(memReq), .memGnt(memGnt), .memAddr(memAddr),
    .memWe(memWe), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata), .memRvalid(memRvalid), .resValid(resValid),
    .resTag(resTag), .resData(resData), .resExc(resExc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One operation through the handshake, expected values from the requirements
  task automatic runOp(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] wd,
                       input logic [3:0] tag, input logic [31:0] rword,
                       input int gntWait);
    logic [31:0] ea, expAddr, expWd, sh, expData;
    logic [1:0]  sz, off;
    logic [3:0]  expBe;
    bit          mis, isSt;
    ea   = a + b;
    off  = ea[1:0];
    sz   = (op[1:0] == 2'd3) ? 2'd2 : op[1:0];
    isSt = op[3];
    mis  = (sz == 2'd1 && off[0]) || (sz == 2'd2 && off != 2'd0);
    expAddr = {ea[31:2], 2'b00};
    expBe   = (sz == 2'd0 ? 4'b0001 : sz == 2'd1 ? 4'b0011 : 4'b1111) << off;
    expWd   = wd << (8 * off);
    sh      = rword >> (8 * off);
    if (isSt) expData = '0;
    else if (sz == 2'd0) expData = op[2] ? {24'h0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
    else if (sz == 2'd1) expData = op[2] ? {16'h0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
    else expData = rword;

    @(negedge clk);
    chk(inReady === 1'b1, "R1", "ready before issue", 32'(inReady), 32'd1);
    inValid = 1'b1; inOp = op; inOpA = a; inOpB = b; inWdata = wd; inTag = tag;
    @(negedge clk);
    inValid = 1'b0; inOp = 4'hF; inOpA = '1; inWdata = '1;
    chk(inReady === 1'b0, "R1", "busy after take", 32'(inReady), 32'd0);
    if (mis) begin
      chk(memReq === 1'b0, "R9", "no request", 32'(memReq), 32'd0);
      chk(resValid === 1'b1 && resExc === 1'b1, "R9", "exc result",
          {30'd0, resValid, resExc}, 32'd3);
      chk(resTag === tag, "R9", "tag", 32'(resTag), 32'(tag));
      chk(resData === 32'd0, "R9", "data", resData, 32'd0);
      @(negedge clk);
      chk(resValid === 1'b0, "R9", "single pulse", 32'(resValid), 32'd0);
      return;
    end
    chk(memReq === 1'b1, "R2", "request raised", 32'(memReq), 32'd1);
    chk(memWe === isSt, "R3", "write enable", 32'(memWe), 32'(isSt));
    chk(memAddr === expAddr, "R4", "address", memAddr, expAddr);
    chk(memBe === expBe, "R5", "byte enables", 32'(memBe), 32'(expBe));
    if (isSt) chk(memWdata === expWd, "R6", "store lanes", memWdata, expWd);
    for (int i = 0; i < gntWait; i++) begin
      @(negedge clk);
      chk(memReq === 1'b1 && memAddr === expAddr && memBe === expBe,
          "R2", "held while ungranted", memAddr, expAddr);
    end
    memGnt = 1'b1;
    @(negedge clk);
    memGnt = 1'b0;
    chk(memReq === 1'b0, "R2", "drop after grant", 32'(memReq), 32'd0);
    chk(resValid === 1'b0, "R8", "no early result", 32'(resValid), 32'd0);
    memRvalid = 1'b1; memRdata = rword;
    @(negedge clk);
    memRvalid = 1'b0; memRdata = 32'hDEADBEEF;
    chk(resValid === 1'b1 && resExc === 1'b0, "R8", "result valid",
        {30'd0, resValid, resExc}, 32'd2);
    chk(resTag === tag, "R8", "tag", 32'(resTag), 32'(tag));
    chk(resData === expData, isSt ? "R8" : "R7", "result data", resData, expData);
    @(negedge clk);
    chk(resValid === 1'b0, "R8", "single pulse", 32'(resValid), 32'd0);
    chk(inReady === 1'b1, "R1", "ready again", 32'(inReady), 32'd1);
  endtask

  task automatic testReset();
    chk(inReady === 1'b1 && memReq === 1'b0 && resValid === 1'b0, "R1",
        "reset state", {29'd0, inReady, memReq, resValid}, 32'd4);
  endtask
  task automatic testLoadByteSigned();   // R7
    runOp(4'b0000, 32'h1000, 32'h3, 32'h0, 4'h1, 32'h80123456, 0);
  endtask
  task automatic testLoadByteUnsigned(); // R7
    runOp(4'b0100, 32'h2000, 32'h1, 32'h0, 4'h2, 32'h1234F600, 2);
  endtask
  task automatic testLoadHalf();         // R7
    runOp(4'b0001, 32'h3000, 32'h2, 32'h0, 4'h3, 32'h9ABC0000, 1);
    runOp(4'b0101, 32'h3000, 32'h2, 32'h0, 4'h4, 32'h9ABC0000, 0);
    runOp(4'b0001, 32'h3000, 32'h0, 32'h0, 4'h5, 32'h00007FFE, 0);
  endtask
  task automatic testLoadWord();         // R7
    runOp(4'b0010, 32'h4000, 32'h8, 32'h0, 4'h6, 32'hCAFEF00D, 3);
  endtask
  task automatic testStores();           // R3 R5 R6
    runOp(4'b1000, 32'h5000, 32'h1, 32'h000000A5, 4'h7, 32'h0, 0);
    runOp(4'b1001, 32'h5000, 32'h2, 32'h0000BEEF, 4'h8, 32'h0, 1);
    runOp(4'b1010, 32'h5000, 32'h4, 32'h01234567, 4'h9, 32'h0, 4);
    runOp(4'b1011, 32'h5100, 32'h0, 32'h89ABCDEF, 4'hA, 32'h0, 0);
  endtask
  task automatic testAddrWrap();         // R4
    runOp(4'b0000, 32'hFFFFFFFE, 32'h3, 32'h0, 4'hB, 32'h000000FF, 0);
  endtask
  task automatic testMisaligned();       // R9
    runOp(4'b0001, 32'h6000, 32'h1, 32'h0, 4'hC, 32'h0, 0);
    runOp(4'b1010, 32'h6000, 32'h2, 32'h11, 4'hD, 32'h0, 0);
    runOp(4'b0110, 32'h6001, 32'h2, 32'h0, 4'hE, 32'h0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoadByteSigned();
    testLoadByteUnsigned();
    testLoadHalf();
    testLoadWord();
    testStores();
    testAddrWrap();
    testMisaligned();
    testLoadWord();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule